// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. It runs one recoding step per clock. Each step looks at the lowest bit of the remaining multiplier together with the bit that sat just below it. That pair decides whether the multiplicand is subtracted from the upper half of a running product, added to it, or left out. The whole running product then shifts right by one place, and the sign bit is copied into the vacated top position.

A client raises `start` for one cycle while `busy` is low, with both operands valid on that cycle. The block then computes for exactly `WIDTH` cycles. It ends with a single-cycle `done` pulse. The product on `product_o` is registered and stays stable until the next operation completes.

Top module: `booth_mul`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `product_o` are all 0.
- R2: A `start` sampled high while `busy` is low captures both operands. `busy` is high in the cycle after that edge and stays high for exactly `WIDTH` cycles.
- R3: When the recoded pair {multiplier bit, right neighbour} is 10, the multiplicand is subtracted from the upper half of the running product.
- R4: When the pair is 01, the multiplicand is added to the upper half. When the pair is 00 or 11, the upper half is only shifted.
- R5: The right-neighbour bit is 0 at the first step. After each step it holds the bit that left the bottom of the running product.
- R6: Every step ends with an arithmetic right shift: the top bit is copied, not zero-filled. The upper half carries one guard bit, so the most negative multiplicand gives the right result.
- R7: `done` is a one-cycle pulse on the cycle in which `busy` falls. `product_o` changes on that same edge and then holds its value.
- R8: A `start` raised while `busy` is high has no effect on the running operation or on its result.
- R9: `product_o` equals the signed product of the captured operands. At width 4, 2 × 7 gives 14 and 2 × −3 gives −6, each after 4 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication (accepted when idle) |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | High while recoding steps run |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*WIDTH | Registered signed product |

## Verification
The edge that samples `start` is called edge k. `busy` must read high after edge k and on every cycle through edge k+WIDTH−1. `done` and the new `product_o` must appear after edge k+WIDTH, and `done` must clear again after edge k+WIDTH+1, while the product keeps its value. The bench drives and samples only on falling edges. It counts falling edges from the `start` edge and checks every intermediate cycle, so a result that arrives one cycle early or late is reported. Operand sets cover every signed pair at width 4, the most negative operands, a second `start` during a run, and random pairs at width 32.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } booth_state_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      right_bit,
  output booth_op_e op
);
  always_comb begin
    unique case ({cur_bit, right_bit})
      2'b10:   op = OP_SUB;   // entering a run of ones
      2'b01:   op = OP_ADD;   // leaving a run of ones
      default: op = OP_NONE;  // inside a run
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH:0]   acc,
  input  logic [WIDTH-1:0] mcand,
  input  booth_op_e        op,
  output logic [WIDTH:0]   sum
);
  logic [WIDTH:0] mcand_ext;
  assign mcand_ext = {mcand[WIDTH-1], mcand};

  always_comb begin
    unique case (op)
      OP_ADD:  sum = acc + mcand_ext;
      OP_SUB:  sum = acc - mcand_ext;
      default: sum = acc;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  booth_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy = (state_q == ST_RUN);
  assign load = start && !busy;
  assign step = busy;
  assign last = busy && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (load) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) state_q <= ST_IDLE;
    end
  end

  AST_START_ENTERS_RUN: assert property (@(posedge clk) disable iff (rst)
    load |=> busy && (cnt_q == '0)); // R2
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= LAST_CNT)); // R2
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [WIDTH-1:0]     mcand_i,
  input  logic [WIDTH-1:0]     mplier_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [2*WIDTH-1:0]   product_o
);
  localparam int PW = 2 * WIDTH;

  logic             load, step, last, busy;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH:0]   hi_q;        // upper half plus guard bit
  logic [WIDTH-1:0] lo_q;        // remaining multiplier / low product
  logic             right_q;     // implicit bit right of lo_q[0]
  logic [WIDTH:0]   sum;
  logic [WIDTH:0]   hi_next;
  logic [WIDTH-1:0] lo_next;
  booth_op_e        op;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .last(last), .busy(busy)
  );

  booth_recode u_recode (
    .cur_bit(lo_q[0]), .right_bit(right_q), .op(op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc(hi_q), .mcand(mcand_q), .op(op), .sum(sum)
  );

  assign hi_next = {sum[WIDTH], sum[WIDTH:1]};
  assign lo_next = {sum[0], lo_q[WIDTH-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q   <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      right_q   <= 1'b0;
      done_o    <= 1'b0;
      product_o <= '0;
    end else begin
      done_o <= last;
      if (load) begin
        mcand_q <= mcand_i;
        hi_q    <= '0;
        lo_q    <= mplier_i;
        right_q <= 1'b0;
      end else if (step) begin
        hi_q    <= hi_next;
        lo_q    <= lo_next;
        right_q <= lo_q[0];
        if (last) product_o <= PW'({hi_next[WIDTH-1:0], lo_next});
      end
    end
  end

  assign busy_o = busy;

  AST_NOP_SHIFT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (step && op == OP_NONE) |=> hi_q == {$past(hi_q[WIDTH]), $past(hi_q[WIDTH:1])}); // R4
  AST_RIGHT_BIT_TRACK: assert property (@(posedge clk) disable iff (rst)
    step |=> right_q == $past(lo_q[0])); // R5
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    step |=> hi_q[WIDTH] == hi_q[WIDTH-1]); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R7
  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(product_o)); // R7
endmodule

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
  localparam int N4  = 4;
  localparam int N32 = 32;

  logic clk = 1'b0;
  logic rst;
  logic start4, start32;
  logic [N4-1:0]    a4, b4;
  logic [N32-1:0]   a32, b32;
  logic             busy4, done4, busy32, done32;
  logic [2*N4-1:0]  p4;
  logic [2*N32-1:0] p32;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;   // 4 ns period

  booth_mul #(.WIDTH(N4)) u_dut (
    .clk(clk), .rst(rst), .start(start4), .mcand_i(a4), .mplier_i(b4),
    .busy_o(busy4), .done_o(done4), .product_o(p4)
  );

  booth_mul #(.WIDTH(N32)) u_dut32 (
    .clk(clk), .rst(rst), .start(start32), .mcand_i(a32), .mplier_i(b32),
    .busy_o(busy32), .done_o(done32), .product_o(p32)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One width-4 operation: start seen at edge k, busy through k+N-1, done after k+N.
  task automatic run4(input int a, input int b, input string req, input bit glitch_start = 0);
    int  exp_p = a * b;
    logic [2*N4-1:0] exp_v = exp_p[2*N4-1:0];
    @(negedge clk);
    a4 = a[N4-1:0]; b4 = b[N4-1:0]; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    check("R2 busy after start", busy4, 1);
    for (int i = 1; i < N4; i++) begin
      if (glitch_start && i == 1) begin
        a4 = 4'sd7; b4 = 4'sd7; start4 = 1'b1;   // R8: must be ignored
      end
      @(negedge clk);
      start4 = 1'b0;
      check("R2 busy held", busy4, 1);
      check("R7 no early done", done4, 0);
    end
    @(negedge clk);
    check("R7 done pulse", done4, 1);
    check("R2 busy dropped", busy4, 0);
    check(req, longint'(p4), longint'(exp_v));
    @(negedge clk);
    check("R7 done single cycle", done4, 0);
    check("R7 product held", longint'(p4), longint'(exp_v));
  endtask

  task automatic run32(input int a, input int b);
    longint exp_p = longint'(a) * longint'(b);
    @(negedge clk);
    a32 = a; b32 = b; start32 = 1'b1;
    @(negedge clk);
    start32 = 1'b0;
    repeat (N32 - 1) @(negedge clk);
    check("R7 done32 not early", done32, 0);
    @(negedge clk);
    check("R7 done32 pulse", done32, 1);
    check("R9 width32 product", longint'(p32), exp_p);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy reset", busy4, 0);
    check("R1 done reset", done4, 0);
    check("R1 product reset", longint'(p4), 0);
    check("R1 product32 reset", longint'(p32), 0);
  endtask

  task automatic t_worked_examples();
    run4(2, 7, "R9 2x7");
    run4(2, -3, "R9 2x-3");
  endtask

  task automatic t_pair_patterns();
    run4(5, 1, "R3 R4 pair10 then 01");      // 0001: sub, add, nop, nop
    run4(3, -1, "R4 R5 run of ones 11");     // 1111: sub then 11 steps
    run4(-6, 6, "R3 R4 mixed runs");         // 0110
    run4(7, -8, "R5 first step neighbour 0");
  endtask

  task automatic t_most_negative();
    run4(-8, -8, "R6 most negative squared");
    run4(-8, 7, "R6 most negative x max");
    run4(-8, 1, "R6 most negative x 1");
  endtask

  task automatic t_start_ignored();
    run4(-5, 3, "R8 start during busy ignored", 1'b1);
  endtask

  task automatic t_exhaustive();
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        run4(a, b, "R9 exhaustive width4");
  endtask

  task automatic t_random32();
    run32(32'h8000_0000, 32'h8000_0000);
    run32(32'h8000_0000, 32'h7fff_ffff);
    run32(-1, -1);
    for (int i = 0; i < 40; i++) run32($urandom, $urandom);
  endtask

  initial begin
    rst = 1'b1; start4 = 1'b0; start32 = 1'b0;
    a4 = '0; b4 = '0; a32 = '0; b32 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_worked_examples();
    t_pair_patterns();
    t_most_negative();
    t_start_ignored();
    t_exhaustive();
    t_random32();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule